// File: doc/BRIEF.md
# Banked Binary-Point Register Block

This block holds the binary-point settings of an interrupt controller's CPU interface. A binary point splits an 8-bit interrupt priority into a group-priority part and a subpriority part. The block keeps five 3-bit fields:

- one group-0 field;
- a group-1 field for the secure world;
- a group-1 field for the non-secure world;
- a virtual group-0 field;
- a virtual group-1 field.

Software reaches the fields through a single-cycle request port. A request names only group 0 or group 1. The block then works out which field the access really reaches from the requester's context:

- its privilege level and security state;
- whether monitor mode is active;
- whether the highest privilege level exists;
- the common-binary-point controls;
- the hypervisor redirect bits.

The block applies the clamping, aliasing, saturation and write-ignore rules on the way. Alongside the port, it continuously presents the effective binary point of group 0, secure group 1 and non-secure group 1. A downstream priority-mask stage consumes these three values.

Read data is registered and appears one cycle after the request. The effective outputs are also registered, so they follow the stored state and the context with one cycle of delay. The minimum values for the two group-1 banks are parameters, 2 for secure and 3 for non-secure by default.

Top module: `bp_regs`

## Requirements
- R1: Only bits [2:0] of a write value are used; bits above are ignored, before any clamping is applied.
- R2: After synchronous reset all five fields are zero, so a plain group-0 read returns 0 and group-1 reads return the applicable minimum; rd_valid is low.
- R3: Without redirection, a group-0 (req_grp1=0) write stores to and a group-0 read returns the group-0 field, never a group-1 field.
- R4: When cur_el is 1 (OS level), is_secure is 0 and redir_fiq is 1, group-0 reads and writes use the virtual group-0 field instead.
- R5: When cur_el is 1, is_secure is 0 and redir_irq is 1, group-1 accesses use the virtual path: the read returns min(virtual group-0 + 1, 7) if vcbpr is 1, else the virtual group-1 field. A write stores the virtual group-1 field, or is ignored if vcbpr is 1.
- R6: A group-1 access uses the secure bank when is_secure is 1, cur_el is not 3 and in_monitor is 0. Otherwise it uses the non-secure bank.
- R7: A secure-bank read returns the group-0 field when cbpr_s is 1 (the requester is never at level 3 or in monitor mode on this path). Otherwise it returns max(secure group-1, MIN_S).
- R8: A secure-bank write is first raised to at least MIN_S. It is then stored in group 0 when has_top and cbpr_s are both 1, and in secure group 1 otherwise.
- R9: A non-secure-bank access aliases when has_top is 1, cur_el is not 3, in_monitor is 0 and cbpr_ns is 1. An aliased read returns min(group-0 + 1, 7), and an aliased write changes nothing.
- R10: An unaliased non-secure-bank read returns max(non-secure group-1, MIN_NS). An unaliased write stores max(value, MIN_NS).
- R11: The outputs eff_g0, eff_g1s and eff_g1ns equal what a group-0 read, a secure-bank group-1 read and a non-secure-bank group-1 read would return under the current context, one cycle later.
- R12: A read (req_valid=1, req_write=0) raises rd_valid with rd_data one cycle later. Writes and idle cycles leave rd_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_grp1 | input | 1 | 0 = group-0 register, 1 = group-1 register |
| req_wdata | input | DATA_W | Write value |
| cur_el | input | EL_W | Privilege level of the requester (1 = OS, 3 = top) |
| is_secure | input | 1 | Requester is in secure state |
| in_monitor | input | 1 | Requester is in monitor mode |
| has_top | input | 1 | Highest privilege level is implemented |
| cbpr_s | input | 1 | Secure common-binary-point control |
| cbpr_ns | input | 1 | Non-secure common-binary-point control |
| vcbpr | input | 1 | Virtual common-binary-point control |
| redir_fiq | input | 1 | Hypervisor redirect of group 0 to virtual |
| redir_irq | input | 1 | Hypervisor redirect of group 1 to virtual |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data, zero-extended 3-bit value |
| eff_g0 | output | 3 | Effective group-0 binary point |
| eff_g1s | output | 3 | Effective secure group-1 binary point |
| eff_g1ns | output | 3 | Effective non-secure group-1 binary point |

## Verification
A write that lands in the wrong bank, or a clamp that is missed, is invisible at the moment of the write. It shows up on the next read of the affected group. It also shows up on the effective outputs, which reflect the change one cycle after the write edge, whatever the requests do. Aliasing errors are the subtle case: an aliased non-secure write that leaks into storage surfaces only once the aliasing control is cleared. The stimulus therefore keeps changing the context between writes and reads. The effective outputs are compared at intervals throughout, so that a corrupted field is seen within a few operations.

// File: rtl/bp_pkg.sv
package bp_pkg;

  localparam int BP_W = 3;
  localparam int NFLD = 5;

  typedef logic [BP_W-1:0] bp_t;

  // field slots in the storage array
  localparam int F_G0   = 0;
  localparam int F_G1S  = 1;
  localparam int F_G1NS = 2;
  localparam int F_V0   = 3;
  localparam int F_V1   = 4;

  typedef struct packed {
    logic redir0;      // group 0 goes to virtual
    logic redir1;      // group 1 goes to virtual
    logic sec_bank;    // group 1 uses secure bank
    logic s_alias_rd;  // secure group-1 read aliases group 0
    logic s_alias_wr;  // secure group-1 write lands in group 0
    logic ns_alias;    // non-secure group-1 reads g0+1, writes ignored
  } ctx_t;

  function automatic bp_t sat_inc(bp_t v);
    return (v == '1) ? v : bp_t'(v + 1'b1);
  endfunction

  function automatic bp_t raise_to(bp_t v, bp_t floor_v);
    return (v > floor_v) ? v : floor_v;
  endfunction

endpackage

// File: rtl/bp_ctx_decode.sv
module bp_ctx_decode
  import bp_pkg::*;
#(
  parameter int EL_W   = 2,
  parameter int OS_EL  = 1,
  parameter int TOP_EL = 3
) (
  input  logic [EL_W-1:0] cur_el,
  input  logic            is_secure,
  input  logic            in_monitor,
  input  logic            has_top,
  input  logic            cbpr_s,
  input  logic            cbpr_ns,
  input  logic            redir_fiq,
  input  logic            redir_irq,
  output ctx_t            ctx
);

  logic at_os_ns;
  logic top_or_mon;

  always_comb begin
    at_os_ns   = (cur_el == EL_W'(OS_EL)) && !is_secure;
    top_or_mon = (cur_el == EL_W'(TOP_EL)) || in_monitor;

    ctx.redir0     = at_os_ns && redir_fiq;
    ctx.redir1     = at_os_ns && redir_irq;
    ctx.sec_bank   = is_secure && !top_or_mon;
    ctx.s_alias_rd = cbpr_s && !top_or_mon;
    ctx.s_alias_wr = has_top && cbpr_s && !top_or_mon;
    ctx.ns_alias   = has_top && cbpr_ns && !top_or_mon;
  end

endmodule

// File: rtl/bp_bank.sv
module bp_bank
  import bp_pkg::*;
#(
  parameter int MIN_S  = 2,
  parameter int MIN_NS = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_req,
  input  logic                      grp1,
  input  bp_t                       wr_raw,
  input  ctx_t                      ctx,
  input  logic                      vcbpr,
  output logic [NFLD-1:0]           wr_en,
  output logic [NFLD-1:0][BP_W-1:0] fld
);

  localparam bp_t FLOOR_S  = bp_t'(MIN_S);
  localparam bp_t FLOOR_NS = bp_t'(MIN_NS);

  bp_t wr_val;

  // route one write to at most one field
  always_comb begin
    wr_en  = '0;
    wr_val = wr_raw;
    if (wr_req) begin
      if (!grp1) begin
        if (ctx.redir0) wr_en[F_V0] = 1'b1;
        else            wr_en[F_G0] = 1'b1;
      end else if (ctx.redir1) begin
        if (!vcbpr) wr_en[F_V1] = 1'b1;
      end else if (ctx.sec_bank) begin
        wr_val = raise_to(wr_raw, FLOOR_S);
        if (ctx.s_alias_wr) wr_en[F_G0]  = 1'b1;
        else                wr_en[F_G1S] = 1'b1;
      end else begin
        wr_val = raise_to(wr_raw, FLOOR_NS);
        if (!ctx.ns_alias) wr_en[F_G1NS] = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    always_ff @(posedge clk) begin
      if (rst)           fld[i] <= '0;
      else if (wr_en[i]) fld[i] <= wr_val;
    end
  end

endmodule

// File: rtl/bp_read_path.sv
module bp_read_path
  import bp_pkg::*;
#(
  parameter int MIN_S  = 2,
  parameter int MIN_NS = 3
) (
  input  logic [NFLD-1:0][BP_W-1:0] fld,
  input  ctx_t                      ctx,
  input  logic                      vcbpr,
  input  logic                      grp1,
  output bp_t                       rd_val,
  output bp_t                       eff_g0,
  output bp_t                       eff_g1s,
  output bp_t                       eff_g1ns
);

  localparam bp_t FLOOR_S  = bp_t'(MIN_S);
  localparam bp_t FLOOR_NS = bp_t'(MIN_NS);

  bp_t virt1, sec1, nsec1, g1_val;

  always_comb begin
    virt1 = vcbpr ? sat_inc(fld[F_V0]) : fld[F_V1];
    sec1  = ctx.s_alias_rd ? fld[F_G0] : raise_to(fld[F_G1S], FLOOR_S);
    nsec1 = ctx.ns_alias ? sat_inc(fld[F_G0]) : raise_to(fld[F_G1NS], FLOOR_NS);

    eff_g0   = ctx.redir0 ? fld[F_V0] : fld[F_G0];
    eff_g1s  = ctx.redir1 ? virt1 : sec1;
    eff_g1ns = ctx.redir1 ? virt1 : nsec1;

    g1_val = ctx.sec_bank ? eff_g1s : eff_g1ns;
    rd_val = grp1 ? g1_val : eff_g0;
  end

endmodule

// File: rtl/bp_regs.sv
module bp_regs
  import bp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int EL_W   = 2,
  parameter int MIN_S  = 2,
  parameter int MIN_NS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_grp1,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [EL_W-1:0]   cur_el,
  input  logic              is_secure,
  input  logic              in_monitor,
  input  logic              has_top,
  input  logic              cbpr_s,
  input  logic              cbpr_ns,
  input  logic              vcbpr,
  input  logic              redir_fiq,
  input  logic              redir_irq,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [2:0]        eff_g0,
  output logic [2:0]        eff_g1s,
  output logic [2:0]        eff_g1ns
);

  ctx_t                      ctx;
  logic [NFLD-1:0]           wr_en;
  logic [NFLD-1:0][BP_W-1:0] fld;
  bp_t                       rd_val, e0, e1s, e1ns;

  bp_ctx_decode #(.EL_W(EL_W)) u_ctx (
    .cur_el(cur_el), .is_secure(is_secure), .in_monitor(in_monitor),
    .has_top(has_top), .cbpr_s(cbpr_s), .cbpr_ns(cbpr_ns),
    .redir_fiq(redir_fiq), .redir_irq(redir_irq), .ctx(ctx)
  );

  bp_bank #(.MIN_S(MIN_S), .MIN_NS(MIN_NS)) u_bank (
    .clk(clk), .rst(rst), .wr_req(req_valid && req_write),
    .grp1(req_grp1), .wr_raw(req_wdata[BP_W-1:0]), .ctx(ctx),
    .vcbpr(vcbpr), .wr_en(wr_en), .fld(fld)
  );

  bp_read_path #(.MIN_S(MIN_S), .MIN_NS(MIN_NS)) u_rd (
    .fld(fld), .ctx(ctx), .vcbpr(vcbpr), .grp1(req_grp1),
    .rd_val(rd_val), .eff_g0(e0), .eff_g1s(e1s), .eff_g1ns(e1ns)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      eff_g0   <= '0;
      eff_g1s  <= '0;
      eff_g1ns <= '0;
    end else begin
      rd_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rd_data <= DATA_W'(rd_val);
      eff_g0   <= e0;
      eff_g1s  <= e1s;
      eff_g1ns <= e1ns;
    end
  end

endmodule

// File: rtl/bp_regs_chk.sv
module bp_regs_chk
  import bp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MIN_NS = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_grp1,
  input logic              vcbpr,
  input ctx_t              ctx,
  input logic [NFLD-1:0]   wr_en,
  input bp_t               fld_ns,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data
);

  // R12
  read_gives_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);

  // R12
  no_read_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rd_valid);

  // R8
  single_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));

  // R9
  ns_alias_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_grp1 && !ctx.redir1 && !ctx.sec_bank && ctx.ns_alias)
    |=> $stable(fld_ns));

  // R10
  ns_read_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_grp1 && !ctx.redir1 && !ctx.sec_bank && !ctx.ns_alias)
    |=> (rd_data >= DATA_W'(MIN_NS)));

  // R5
  virt_alias_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_grp1 && ctx.redir1 && vcbpr)
    |=> (rd_data != '0));

endmodule

bind bp_regs bp_regs_chk #(.DATA_W(DATA_W), .MIN_NS(MIN_NS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_grp1(req_grp1), .vcbpr(vcbpr), .ctx(ctx), .wr_en(wr_en),
  .fld_ns(fld[bp_pkg::F_G1NS]), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/bp_regs_bench.sv
module bp_regs_bench;

  localparam int DATA_W = 8;
  localparam int MIN_S  = 2;
  localparam int MIN_NS = 3;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_write, req_grp1;
  logic [DATA_W-1:0] req_wdata;
  logic [1:0] cur_el;
  logic is_secure, in_monitor, has_top, cbpr_s, cbpr_ns, vcbpr, redir_fiq, redir_irq;
  logic rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic [2:0] eff_g0, eff_g1s, eff_g1ns;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model fields: g0, g1 secure, g1 non-secure, virtual 0, virtual 1
  int m_g0, m_s, m_ns, m_v0, m_v1;

  always #5 clk = ~clk;

  bp_regs #(.DATA_W(DATA_W), .MIN_S(MIN_S), .MIN_NS(MIN_NS)) u_bp_regs (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_grp1(req_grp1), .req_wdata(req_wdata), .cur_el(cur_el),
    .is_secure(is_secure), .in_monitor(in_monitor), .has_top(has_top),
    .cbpr_s(cbpr_s), .cbpr_ns(cbpr_ns), .vcbpr(vcbpr),
    .redir_fiq(redir_fiq), .redir_irq(redir_irq), .rd_valid(rd_valid),
    .rd_data(rd_data), .eff_g0(eff_g0), .eff_g1s(eff_g1s), .eff_g1ns(eff_g1ns)
  );

  function automatic int inc7(int v); return (v >= 7) ? 7 : v + 1; endfunction
  function automatic int maxi(int a, int b); return (a > b) ? a : b; endfunction
  function automatic bit top_mon(); return (cur_el == 2'd3) || in_monitor; endfunction
  function automatic bit r0(); return cur_el == 2'd1 && !is_secure && redir_fiq; endfunction
  function automatic bit r1(); return cur_el == 2'd1 && !is_secure && redir_irq; endfunction
  function automatic bit sbank(); return is_secure && !top_mon(); endfunction
  function automatic bit nsal(); return has_top && cbpr_ns && !top_mon(); endfunction
  function automatic int virt1(); return vcbpr ? inc7(m_v0) : m_v1; endfunction
  function automatic int exp_g0(); return r0() ? m_v0 : m_g0; endfunction
  function automatic int exp_s();
    if (r1()) return virt1();
    return (cbpr_s && !top_mon()) ? m_g0 : maxi(m_s, MIN_S);
  endfunction
  function automatic int exp_ns();
    if (r1()) return virt1();
    return nsal() ? inc7(m_g0) : maxi(m_ns, MIN_NS);
  endfunction
  function automatic int exp_rd(bit g1);
    if (!g1) return exp_g0();
    return sbank() ? exp_s() : exp_ns();
  endfunction

  task automatic model_write(bit g1, int raw);
    int v = raw & 7;
    if (!g1) begin
      if (r0()) m_v0 = v; else m_g0 = v;
    end else if (r1()) begin
      if (!vcbpr) m_v1 = v;
    end else if (sbank()) begin
      v = maxi(v, MIN_S);
      if (has_top && cbpr_s) m_g0 = v; else m_s = v;
    end else if (!nsal()) begin
      m_ns = maxi(v, MIN_NS);
    end
  endtask

  task automatic chk(string tag, int got, int expv);
    n_cmp++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, expv);
    end
  endtask

  task automatic set_ctx(int el, bit sec, bit mon, bit top, bit cs, bit cns,
                         bit vc, bit fiq, bit irq);
    @(negedge clk);
    cur_el = 2'(el); is_secure = sec; in_monitor = mon; has_top = top;
    cbpr_s = cs; cbpr_ns = cns; vcbpr = vc; redir_fiq = fiq; redir_irq = irq;
  endtask

  task automatic access(bit wr, bit g1, int data, string tag);
    int e;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_grp1 = g1; req_wdata = DATA_W'(data);
    e = exp_rd(g1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) begin
      chk({tag, " R12 no rd_valid on write"}, int'(rd_valid), 0);
      model_write(g1, data);
    end else begin
      chk({tag, " R12 rd_valid"}, int'(rd_valid), 1);
      chk(tag, int'(rd_data), e);
    end
  endtask

  task automatic chk_eff(string tag);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R11 eff_g0"}, int'(eff_g0), exp_g0());
    chk({tag, " R11 eff_g1s"}, int'(eff_g1s), exp_s());
    chk({tag, " R11 eff_g1ns"}, int'(eff_g1ns), exp_ns());
  endtask

  initial begin
    #(1_500_000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    rst = 1'b1; req_valid = 0; req_write = 0; req_grp1 = 0; req_wdata = '0;
    cur_el = 2'd1; is_secure = 0; in_monitor = 0; has_top = 1;
    cbpr_s = 0; cbpr_ns = 0; vcbpr = 0; redir_fiq = 0; redir_irq = 0;
    m_g0 = 0; m_s = 0; m_ns = 0; m_v0 = 0; m_v1 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 rd_valid after reset", int'(rd_valid), 0);
    rst = 1'b0;
    // reset values
    access(0, 0, 0, "R2 group0 reset read");
    access(0, 1, 0, "R2 ns group1 reset min");
    set_ctx(1, 1, 0, 1, 0, 0, 0, 0, 0);
    access(0, 1, 0, "R2 secure group1 reset min");
    chk_eff("R2 reset");
    // R1 masking, R3 group 0
    access(1, 0, 8'hFD, "R1 masked write");
    access(0, 0, 0, "R1 R3 group0 read after 0xFD");
    // R8 secure write clamp and alias to g0
    access(1, 1, 1, "R8 secure write clamp");
    access(0, 1, 0, "R7 secure clamped read");
    set_ctx(1, 1, 0, 1, 1, 0, 0, 0, 0);
    access(1, 1, 6, "R8 aliased secure write");
    access(0, 0, 0, "R8 group0 got secure alias write");
    access(0, 1, 0, "R7 secure alias read");
    // R6 secure at top uses NS bank
    set_ctx(3, 1, 0, 1, 1, 0, 0, 0, 0);
    access(1, 1, 4, "R6 top-level write to ns bank");
    access(0, 1, 0, "R6 R10 ns bank read");
    // R9 NS alias saturation and write ignore
    set_ctx(2, 0, 0, 1, 0, 1, 0, 0, 0);
    access(1, 0, 7, "R9 set group0 7");
    access(0, 1, 0, "R9 saturated alias read");
    access(1, 1, 5, "R9 ignored write");
    set_ctx(2, 0, 0, 1, 0, 0, 0, 0, 0);
    access(0, 1, 0, "R9 R10 ns after ignored write");
    access(1, 1, 1, "R10 ns clamp write");
    access(0, 1, 0, "R10 ns clamped read");
    set_ctx(2, 0, 0, 0, 0, 1, 0, 0, 0);
    access(0, 1, 0, "R9 no alias without top");
    // R4/R5 redirect
    set_ctx(1, 0, 0, 1, 0, 0, 1, 1, 1);
    access(1, 0, 7, "R4 virtual g0 write");
    access(0, 0, 0, "R4 virtual g0 read");
    access(1, 1, 2, "R5 virtual g1 write ignored");
    access(0, 1, 0, "R5 virtual alias saturated");
    chk_eff("R5 redirect");
    set_ctx(1, 0, 0, 1, 0, 0, 0, 1, 1);
    access(1, 1, 2, "R5 virtual g1 write");
    access(0, 1, 0, "R5 virtual g1 read");
    set_ctx(1, 0, 0, 1, 0, 0, 0, 0, 0);
    access(0, 0, 0, "R3 R4 real group0 untouched");
    chk_eff("R11 directed");
    // random
    for (int i = 0; i < 3000; i++) begin
      int el = int'($urandom_range(3, 0));
      bit sec = 1'($urandom);
      set_ctx(el, sec, sec && ($urandom_range(7, 0) == 0), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      access(1'($urandom), 1'($urandom), int'($urandom_range(255, 0)), "R3-R10 random");
      if (i % 8 == 0) chk_eff("R11 random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule